// File: doc/BRIEF.md
# Pseudo-DMA Staging Bridge

This block sits between a host that moves data by pseudo-DMA (the processor itself reads or writes a data register whenever a request line is high) and a byte stream leading to a SCSI-style device. All bytes pass through a 16-byte staging FIFO. The request output `dreq` lets the host move at most one FIFO load at a time. The block lowers `dreq` whenever the FIFO has to be exchanged with the device side.

Software starts a transfer by writing a byte count and a direction. When the host sends data to the device, the host fills the FIFO. Once the FIFO is full or the count is exhausted, the block streams the FIFO contents to the device and then reopens the host window. When data flows from the device, the block first refills the FIFO from the device stream. The host then empties the FIFO through the data register, and the next refill starts as soon as the FIFO is empty.

The device side uses two valid/ready byte streams. A byte moves on a cycle where valid and ready are both high. On the outgoing stream (`dev_tx_*`) the block holds the offered byte unchanged while `dev_tx_ready` is low. On the incoming stream (`dev_rx_*`) the block raises `dev_rx_ready` only while it is refilling, so the device may hold `dev_rx_valid` high for as long as it likes. Host register reads return data combinationally. Any side effect of a read happens at the clock edge that ends the access.

Top module: `pdma_stage_bridge`

## Requirements
- R1: After reset, `dreq`, `dev_tx_valid` and `dev_rx_ready` are low, and the count, status and pointer registers all read zero.
- R2: A write to the count register (address 1) takes the count from wdata[11:0] and the direction from wdata[15] (0 = host to device, 1 = device to host). It is accepted only while idle and only with a nonzero count. For host to device, `dreq` goes high at the next edge. For device to host, `dev_rx_ready` goes high at the next edge while `dreq` stays low. Any other count write has no effect.
- R3: While `dreq` is high in host-to-device mode, a write to the data register (address 0) pushes bytes and the count drops by one per byte. A 16-bit write (`host_wide` high) pushes wdata[15:8] first and then wdata[7:0]. The second byte is dropped if the count or the FIFO space runs out.
- R4: When the write pointer reaches 16 or the count reaches zero, `dreq` is low from the next edge. The staged bytes then leave on `dev_tx_data` in the order they were written, one per handshake.
- R5: While `dev_tx_valid` is high and `dev_tx_ready` is low, `dev_tx_valid` stays high and `dev_tx_data` stays stable.
- R6: After the last staged byte is accepted, both pointers return to zero. `dreq` rises again if the count is nonzero; otherwise the block goes idle with `dreq` low.
- R7: In device-to-host mode, a refill accepts exactly min(count, 16 − write pointer) bytes, and the count drops by one per accepted byte. `dev_rx_ready` is low outside a refill.
- R8: Completion of a refill sets the terminal-count status bit and raises `dreq`. Accepting a new transfer clears the bit.
- R9: While `dreq` is high in device-to-host mode, a read of the data register pops bytes. A 16-bit read returns the first popped byte in bits 15:8. If only one byte remains, bits 7:0 read zero.
- R10: When a read makes the read pointer equal the write pointer, both pointers return to zero and `dreq` drops. The next refill starts if the count is nonzero; otherwise the block goes idle.
- R11: A data-register read outside the host read window returns zero and leaves the pointers unchanged. A data-register write outside the host write window is ignored.
- R12: A pulse on `cmd_done` forces the block idle at the next edge: `dreq` low, count zero, pointers zero.
- R13: The status register (address 2) shows dreq in bit 0, terminal count in bit 1, direction in bit 2 and busy in bit 3. The pointer register (address 3) shows the write pointer in bits 12:8 and the read pointer in bits 4:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 16-bit access when high, 8-bit when low |
| host_addr | input | 2 | Register select: 0 data, 1 count, 2 status, 3 pointers |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| dreq | output | 1 | Host transfer request |
| cmd_done | input | 1 | Command completion; aborts and idles the bridge |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte to the device |
| dev_tx_ready | input | 1 | Device accepts the offered byte |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_data | input | 8 | Byte from the device |
| dev_rx_ready | output | 1 | Bridge accepts the offered byte |

## Verification
The handshake and pointer properties assume the device obeys the stream rules: it drives `dev_rx_data` meaningfully whenever it raises `dev_rx_valid`, and it may toggle `dev_tx_ready` on any cycle. The hold property on the outgoing stream exempts the cycle where `cmd_done` aborts a transfer. For that reason the stimulus raises `cmd_done` only while nothing is offered to the device. The bench changes every input only at falling edges and makes at most one host access per cycle. It applies stall patterns to `dev_tx_ready` and `dev_rx_valid` so that back-pressure is exercised in both directions.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HFILL  = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_REFILL = 3'd3,
    ST_HDRAIN = 3'd4
  } xfer_state_e;

  localparam logic [1:0] REG_DATA   = 2'd0;
  localparam logic [1:0] REG_COUNT  = 2'd1;
  localparam logic [1:0] REG_STATUS = 2'd2;
  localparam logic [1:0] REG_PTRS   = 2'd3;
  localparam int         DIR_BIT    = 15;
endpackage

// File: rtl/pdma_fifo.sv
module pdma_fifo #(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [1:0]    push_n,
  input  logic [7:0]    push_b0,
  input  logic [7:0]    push_b1,
  input  logic [1:0]    pop_n,
  output logic [7:0]    rd_b0,
  output logic [7:0]    rd_b1,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH*8-1:0] flat;
  logic [AW-1:0]      wa0, wa1, ra0, ra1;

  assign wa0 = wptr[AW-1:0];
  assign wa1 = wa0 + AW'(1);
  assign ra0 = rptr[AW-1:0];
  assign ra1 = ra0 + AW'(1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (push_n != 2'd0 && wa0 == AW'(i)) byte_q <= push_b0;
      else if (push_n == 2'd2 && wa1 == AW'(i)) byte_q <= push_b1;
    end
    assign flat[i*8 +: 8] = byte_q;
  end

  assign rd_b0 = flat[{ra0, 3'b000} +: 8];
  assign rd_b1 = flat[{ra1, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      wptr <= wptr + PW'(push_n);
      rptr <= rptr + PW'(pop_n);
    end
  end

  AST_PTR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr <= wptr) && (wptr <= PW'(DEPTH))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 2'd0) |-> ((PW + 1)'(wptr) + (PW + 1)'(push_n) <= (PW + 1)'(DEPTH))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_n != 2'd0) |-> (PW'(pop_n) <= wptr - rptr)); // R9
endmodule

// File: rtl/pdma_host_if.sv
module pdma_host_if
  import pdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH) + 1,
  parameter int CNT_W = 12
) (
  input  logic            host_sel,
  input  logic            host_wr,
  input  logic            host_wide,
  input  logic [1:0]      host_addr,
  input  logic [15:0]     host_wdata,
  output logic [15:0]     host_rdata,
  input  xfer_state_e     state,
  input  logic [CNT_W-1:0] cnt,
  input  logic            dir,
  input  logic            tc,
  input  logic            dreq,
  input  logic [PW-1:0]   wptr,
  input  logic [PW-1:0]   rptr,
  input  logic [7:0]      rd_b0,
  input  logic [7:0]      rd_b1,
  output logic [1:0]      hpush_n,
  output logic [7:0]      hpush_b0,
  output logic [7:0]      hpush_b1,
  output logic [1:0]      hpop_n,
  output logic            load_req,
  output logic [CNT_W-1:0] load_cnt,
  output logic            load_dir
);
  logic [PW-1:0] room, avail;
  logic          data_wr, data_rd;

  assign room    = PW'(DEPTH) - wptr;
  assign avail   = wptr - rptr;
  assign data_wr = host_sel && host_wr && host_addr == REG_DATA && state == ST_HFILL;
  assign data_rd = host_sel && !host_wr && host_addr == REG_DATA && state == ST_HDRAIN;

  always_comb begin
    hpush_n = 2'd0;
    if (data_wr) begin
      if (host_wide && cnt >= CNT_W'(2) && room >= PW'(2)) hpush_n = 2'd2;
      else if (cnt != '0 && room != '0)                     hpush_n = 2'd1;
    end
  end

  assign hpush_b0 = host_wide ? host_wdata[15:8] : host_wdata[7:0];
  assign hpush_b1 = host_wdata[7:0];

  always_comb begin
    hpop_n = 2'd0;
    if (data_rd) begin
      if (host_wide && avail >= PW'(2)) hpop_n = 2'd2;
      else if (avail != '0)             hpop_n = 2'd1;
    end
  end

  assign load_req = host_sel && host_wr && host_addr == REG_COUNT;
  assign load_cnt = host_wdata[CNT_W-1:0];
  assign load_dir = host_wdata[DIR_BIT];

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_wr) begin
      case (host_addr)
        REG_DATA: begin
          if (hpop_n != 2'd0) begin
            if (host_wide) host_rdata = {rd_b0, (hpop_n == 2'd2) ? rd_b1 : 8'h00};
            else           host_rdata = {8'h00, rd_b0};
          end
        end
        REG_COUNT:  host_rdata = 16'(cnt);
        REG_STATUS: host_rdata = {12'h000, state != ST_IDLE, dir, tc, dreq};
        default: begin
          host_rdata[8 +: PW] = wptr;
          host_rdata[0 +: PW] = rptr;
        end
      endcase
    end
  end
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PW    = $clog2(DEPTH) + 1,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             load_dir,
  input  logic             cmd_done,
  input  logic [1:0]       hpush_n,
  input  logic [1:0]       hpop_n,
  input  logic             rx_fire,
  input  logic             tx_fire,
  input  logic [PW-1:0]    wptr,
  input  logic [PW-1:0]    rptr,
  output xfer_state_e      state,
  output logic [CNT_W-1:0] cnt,
  output logic             dir,
  output logic             tc,
  output logic             dreq,
  output logic             fifo_clear
);
  localparam int PW1 = PW + 1;

  xfer_state_e      st_d;
  logic [CNT_W-1:0] cnt_d;
  logic             dir_d, tc_d;

  always_comb begin
    st_d       = state;
    cnt_d      = cnt;
    dir_d      = dir;
    tc_d       = tc;
    fifo_clear = 1'b0;
    if (cmd_done) begin
      st_d       = ST_IDLE;
      cnt_d      = '0;
      fifo_clear = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load_req && load_cnt != '0) begin
            cnt_d      = load_cnt;
            dir_d      = load_dir;
            tc_d       = 1'b0;
            fifo_clear = 1'b1;
            st_d       = load_dir ? ST_REFILL : ST_HFILL;
          end
        end
        ST_HFILL: begin
          if (hpush_n != 2'd0) begin
            cnt_d = cnt - CNT_W'(hpush_n);
            if ((PW1'(wptr) + PW1'(hpush_n)) == PW1'(DEPTH) || cnt_d == '0) st_d = ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (tx_fire && (rptr + PW'(1)) == wptr) begin
            fifo_clear = 1'b1;
            st_d       = (cnt == '0) ? ST_IDLE : ST_HFILL;
          end
        end
        ST_REFILL: begin
          if (rx_fire) begin
            cnt_d = cnt - CNT_W'(1);
            if ((wptr + PW'(1)) == PW'(DEPTH) || cnt_d == '0) begin
              st_d = ST_HDRAIN;
              tc_d = 1'b1;
            end
          end
        end
        ST_HDRAIN: begin
          if (hpop_n != 2'd0 && (rptr + PW'(hpop_n)) == wptr) begin
            fifo_clear = 1'b1;
            st_d       = (cnt != '0) ? ST_REFILL : ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dir   <= 1'b0;
      tc    <= 1'b0;
      dreq  <= 1'b0;
    end else begin
      state <= st_d;
      cnt   <= cnt_d;
      dir   <= dir_d;
      tc    <= tc_d;
      dreq  <= (st_d == ST_HFILL) || (st_d == ST_HDRAIN);
    end
  end

  AST_START_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && load_req && load_cnt != '0 && !load_dir && !cmd_done) |=> dreq); // R2
  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> (cnt <= $past(cnt))); // R3
  AST_TC_AT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dir && $rose(dreq)) |-> tc); // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> (!dreq && cnt == '0)); // R12
endmodule

// File: rtl/pdma_stage_bridge.sv
module pdma_stage_bridge
  import pdma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic        host_wide,
  input  logic [1:0]  host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        dreq,
  input  logic        cmd_done,
  output logic        dev_tx_valid,
  output logic [7:0]  dev_tx_data,
  input  logic        dev_tx_ready,
  input  logic        dev_rx_valid,
  input  logic [7:0]  dev_rx_data,
  output logic        dev_rx_ready
);
  localparam int PW = $clog2(DEPTH) + 1;

  xfer_state_e      state;
  logic [CNT_W-1:0] cnt, load_cnt;
  logic             dir, tc, load_req, load_dir, fifo_clear;
  logic [PW-1:0]    wptr, rptr;
  logic [7:0]       rd_b0, rd_b1, hpush_b0, hpush_b1, push_b0;
  logic [1:0]       hpush_n, hpop_n, push_n, pop_n;
  logic             rx_fire, tx_fire;

  assign dev_tx_valid = (state == ST_DRAIN);
  assign dev_tx_data  = rd_b0;
  assign dev_rx_ready = (state == ST_REFILL);
  assign tx_fire      = dev_tx_valid && dev_tx_ready;
  assign rx_fire      = dev_rx_valid && dev_rx_ready;

  assign push_n  = rx_fire ? 2'd1 : hpush_n;
  assign push_b0 = rx_fire ? dev_rx_data : hpush_b0;
  assign pop_n   = tx_fire ? 2'd1 : hpop_n;

  pdma_fifo #(.DEPTH(DEPTH), .PW(PW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
    .push_n(push_n), .push_b0(push_b0), .push_b1(hpush_b1),
    .pop_n(pop_n), .rd_b0(rd_b0), .rd_b1(rd_b1),
    .wptr(wptr), .rptr(rptr)
  );

  pdma_host_if #(.DEPTH(DEPTH), .PW(PW), .CNT_W(CNT_W)) u_host (
    .host_sel(host_sel), .host_wr(host_wr), .host_wide(host_wide),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .state(state), .cnt(cnt), .dir(dir), .tc(tc), .dreq(dreq),
    .wptr(wptr), .rptr(rptr), .rd_b0(rd_b0), .rd_b1(rd_b1),
    .hpush_n(hpush_n), .hpush_b0(hpush_b0), .hpush_b1(hpush_b1),
    .hpop_n(hpop_n), .load_req(load_req), .load_cnt(load_cnt), .load_dir(load_dir)
  );

  pdma_seq #(.DEPTH(DEPTH), .PW(PW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .load_cnt(load_cnt),
    .load_dir(load_dir), .cmd_done(cmd_done), .hpush_n(hpush_n), .hpop_n(hpop_n),
    .rx_fire(rx_fire), .tx_fire(tx_fire), .wptr(wptr), .rptr(rptr),
    .state(state), .cnt(cnt), .dir(dir), .tc(tc), .dreq(dreq),
    .fifo_clear(fifo_clear)
  );

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid && !dev_tx_ready && !cmd_done) |=> (dev_tx_valid && $stable(dev_tx_data))); // R5
  AST_NO_DREQ_IN_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid || dev_rx_ready) |-> !dreq); // R4
  AST_RX_ONLY_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rx_ready && dreq) |-> 1'b0); // R7
endmodule

// File: tb/sim_pdma_stage_bridge.sv
module sim_pdma_stage_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic [15:0] host_rdata;
  logic        dreq, cmd_done = 1'b0;
  logic        dev_tx_valid, dev_tx_ready = 1'b0;
  logic [7:0]  dev_tx_data;
  logic        dev_rx_valid = 1'b0, dev_rx_ready;
  logic [7:0]  dev_rx_data = 8'h0;

  always #2 clk = ~clk;

  pdma_stage_bridge u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dreq(dreq), .cmd_done(cmd_done),
    .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
    .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready)
  );

  int n_total = 0, n_pass = 0;
  int ncyc = 0;
  int stall = 0;
  bit sink_en = 1'b0, src_en = 1'b0;
  logic [7:0] sink_q [64];
  int sink_n = 0;
  logic [7:0] src_mem [64];
  int src_idx = 0, src_len = 0;

  // bit fields: {dir, wide, stall[1:0], count[11:0]}
  localparam logic [15:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd0, 12'd5},
    {1'b0, 1'b1, 2'd1, 12'd33},
    {1'b0, 1'b1, 2'd2, 12'd16},
    {1'b1, 1'b0, 2'd0, 12'd7},
    {1'b1, 1'b1, 2'd1, 12'd37},
    {1'b1, 1'b0, 2'd2, 12'd16}
  };

  function automatic logic [7:0] pat(int s, int k);
    return 8'(s + k * 5);
  endfunction

  function automatic bit stalled(int c);
    return (stall == 1 && c % 2 == 1) || (stall == 2 && c % 3 == 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
  endtask

  // device sink and source, driven on falling edges
  always @(negedge clk) begin
    bit r, v;
    ncyc++;
    r = sink_en && !stalled(ncyc);
    dev_tx_ready = r;
    if (dev_tx_valid && r && sink_n < 64) begin
      sink_q[sink_n] = dev_tx_data;
      sink_n++;
    end
    v = src_en && src_idx < src_len && !stalled(ncyc + 1);
    dev_rx_valid = v;
    dev_rx_data  = src_mem[src_idx % 64];
    if (v && dev_rx_ready) src_idx++;
  end

  task automatic hwrite(input logic [1:0] a, input bit w, input logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_wide = w; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, input bit w, output logic [15:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b0; host_wide = w; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_sel = 1'b0;
  endtask

  task automatic wait_dreq();
    for (int t = 0; t < 400 && !dreq; t++) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); cmd_done = 1'b1;
    @(posedge clk); #1; cmd_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 dreq", 32'(dreq), 0);
    chk("R1 tx_valid", 32'(dev_tx_valid), 0);
    chk("R1 rx_ready", 32'(dev_rx_ready), 0);
    hread(2'd2, 1'b0, d); chk("R1 status", 32'(d), 0);
    hread(2'd3, 1'b0, d); chk("R1 ptrs", 32'(d), 0);
    hread(2'd1, 1'b0, d); chk("R1 count", 32'(d), 0);

    // R11 data accesses while idle
    hread(2'd0, 1'b1, d); chk("R11 idle read zero", 32'(d), 0);
    hwrite(2'd0, 1'b0, 16'h0055);
    hread(2'd3, 1'b0, d); chk("R11 idle write ignored ptrs", 32'(d), 0);

    // R2 zero count ignored
    hwrite(2'd1, 1'b0, 16'h0000);
    hread(2'd2, 1'b0, d); chk("R2 zero count ignored", 32'(d), 0);

    // R2/R3/R12 partial host fill then abort
    sink_en = 1'b0;
    hwrite(2'd1, 1'b0, 16'd5);
    chk("R2 dreq after load", 32'(dreq), 1);
    hwrite(2'd0, 1'b0, 16'h0011);
    hread(2'd1, 1'b0, d); chk("R3 count after byte", 32'(d), 4);
    hwrite(2'd0, 1'b1, 16'hABCD);
    hread(2'd1, 1'b0, d); chk("R3 count after wide", 32'(d), 2);
    hread(2'd3, 1'b0, d); chk("R13 wptr field", 32'(d), 32'h0300);
    hwrite(2'd1, 1'b0, 16'd9);
    hread(2'd1, 1'b0, d); chk("R2 load while busy ignored", 32'(d), 2);
    hread(2'd0, 1'b0, d); chk("R11 read in fill window", 32'(d), 0);
    hread(2'd3, 1'b0, d); chk("R11 ptrs unchanged", 32'(d), 32'h0300);
    pulse_done();
    chk("R12 dreq low", 32'(dreq), 0);
    hread(2'd1, 1'b0, d); chk("R12 count zero", 32'(d), 0);
    hread(2'd3, 1'b0, d); chk("R12 ptrs zero", 32'(d), 0);
    hread(2'd2, 1'b0, d); chk("R12 status idle", 32'(d), 0);

    // R3 wide write order at the device
    sink_en = 1'b1; sink_n = 0; stall = 0;
    hwrite(2'd1, 1'b0, 16'd2);
    hwrite(2'd0, 1'b1, 16'hABCD);
    chk("R4 dreq drops at full count", 32'(dreq), 0);
    repeat (6) @(negedge clk);
    chk("R3 bytes sent", 32'(sink_n), 2);
    chk("R3 upper byte first", 32'(sink_q[0]), 32'hAB);
    chk("R3 lower byte second", 32'(sink_q[1]), 32'hCD);
    chk("R6 idle after last drain", 32'(dreq), 0);

    // R7/R8/R9/R10 short device-to-host transfer
    src_mem[0] = 8'h21; src_mem[1] = 8'h42; src_mem[2] = 8'h63;
    src_idx = 0; src_len = 3; src_en = 1'b1;
    hwrite(2'd1, 1'b0, 16'h8003);
    chk("R2 no dreq during refill", 32'(dreq), 0);
    chk("R7 rx_ready in refill", 32'(dev_rx_ready), 1);
    wait_dreq();
    hread(2'd2, 1'b0, d); chk("R8 tc set, R13 status", 32'(d), 32'hF);
    hread(2'd3, 1'b0, d); chk("R7 refill size", 32'(d), 32'h0300);
    hread(2'd0, 1'b1, d); chk("R9 wide read order", 32'(d), 32'h2142);
    hread(2'd3, 1'b0, d); chk("R9 rptr advanced", 32'(d), 32'h0302);
    hread(2'd0, 1'b0, d); chk("R9 narrow read", 32'(d), 32'h0063);
    chk("R10 dreq drops when empty", 32'(dreq), 0);
    hread(2'd3, 1'b0, d); chk("R10 ptrs reset", 32'(d), 0);
    hread(2'd2, 1'b0, d); chk("R10 idle status", 32'(d), 32'h6);
    src_en = 1'b0;
    sink_en = 1'b0;
    hwrite(2'd1, 1'b0, 16'd1);
    hread(2'd2, 1'b0, d); chk("R8 tc cleared by load", 32'(d), 32'h9);
    pulse_done();

    // vector table: full transfers under stall patterns
    for (int i = 0; i < 6; i++) begin
      bit vdir, vwide;
      int cnt, seed, done_n, chunk, bad;
      vdir = VEC[i][15]; vwide = VEC[i][14]; stall = int'(VEC[i][13:12]);
      cnt = int'(VEC[i][11:0]); seed = i * 16 + 3;
      done_n = 0;
      if (!vdir) begin
        sink_en = 1'b1; sink_n = 0;
        hwrite(2'd1, 1'b0, 16'(cnt));
        while (done_n < cnt) begin
          wait_dreq();
          chunk = (cnt - done_n < 16) ? cnt - done_n : 16;
          for (int j = 0; j < chunk; ) begin
            if (vwide) begin
              hwrite(2'd0, 1'b1, {pat(seed, done_n + j), pat(seed, done_n + j + 1)});
              j += 2;
            end else begin
              hwrite(2'd0, 1'b0, {8'h00, pat(seed, done_n + j)});
              j += 1;
            end
          end
          chk($sformatf("R4 dreq low after chunk v%0d", i), 32'(dreq), 0);
          done_n += chunk;
          for (int t = 0; t < 200 && sink_n < done_n; t++) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        bad = 0;
        for (int k = 0; k < cnt; k++) if (sink_q[k] !== pat(seed, k)) bad++;
        chk($sformatf("R4 R5 byte order v%0d", i), 32'(bad), 0);
        chk($sformatf("R4 byte total v%0d", i), 32'(sink_n), 32'(cnt));
      end else begin
        for (int k = 0; k < 64; k++) src_mem[k] = pat(seed, k);
        src_idx = 0; src_len = cnt; src_en = 1'b1;
        hwrite(2'd1, 1'b0, 16'h8000 | 16'(cnt));
        while (done_n < cnt) begin
          wait_dreq();
          chunk = (cnt - done_n < 16) ? cnt - done_n : 16;
          hread(2'd3, 1'b0, d);
          chk($sformatf("R7 refill size v%0d", i), 32'(d), 32'(chunk) << 8);
          hread(2'd2, 1'b0, d);
          chk($sformatf("R8 tc at refill v%0d", i), 32'(d[1]), 1);
          bad = 0;
          for (int j = 0; j < chunk; ) begin
            if (vwide) begin
              hread(2'd0, 1'b1, d);
              if (d !== {pat(seed, done_n + j),
                         (chunk - j >= 2) ? pat(seed, done_n + j + 1) : 8'h00}) bad++;
              j += 2;
            end else begin
              hread(2'd0, 1'b0, d);
              if (d !== {8'h00, pat(seed, done_n + j)}) bad++;
              j += 1;
            end
          end
          chk($sformatf("R9 chunk data v%0d", i), 32'(bad), 0);
          chk($sformatf("R10 dreq low after empty v%0d", i), 32'(dreq), 0);
          done_n += chunk;
        end
        src_en = 1'b0;
      end
      hread(2'd1, 1'b0, d); chk($sformatf("R6 count zero v%0d", i), 32'(d), 0);
      hread(2'd2, 1'b0, d); chk($sformatf("R6 not busy v%0d", i), 32'(d[3]), 0);
      chk($sformatf("R6 dreq idle v%0d", i), 32'(dreq), 0);
    end

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule